// File: doc/BRIEF.md
# Stochastic Bitstream Multiplier

This block multiplies two fractions in the range 0 to 1 without a multiplier array. Each operand is an 8-bit binary number whose value is operand/256. On a start request the block turns each operand into a serial bitstream. At every position of that stream the chance of a one equals the operand's fraction, and the ones land at pseudo-random places rather than being packed together. The value of a stream is the number of ones in the window divided by the window length. Two such streams, made from uncorrelated generators, are combined one bit per cycle by a single AND gate. The density of ones in the result is the product of the two densities.

A counter totals the ones in the product stream over a window of 256 cycles, which turns the result back into binary. At the end of the window a one-cycle done pulse marks the count as valid. The count stays on the output until the next start. The result is an estimate: an operand of zero always gives exactly zero, and otherwise the count lies within a stated distance of the exact product.

Top module: `stoch_mul`

## Requirements
- R1: After reset, `done_o` is low and `result_o` is 0, and both stay that way until a start is accepted.
- R2: A start is accepted only while no multiplication is running, and both operands are captured at that moment. A start or operand change during a run has no effect on that run's result.
- R3: Each stream comes from its own 8-bit generator that shifts left once per run cycle, with the new bit 0 equal to the XOR of the tapped bits. Stream A taps bits {7,5,4,3} and reloads seed 0x01 at start. Stream B taps bits {7,6,5,0} and reloads seed 0xA5 at start. A stream bit is one when the generator's current value is below the stream's operand.
- R4: In each run cycle the product bit is the AND of the two stream bits, and the count grows by exactly that bit. The count therefore never rises by more than one per cycle and never exceeds 256.
- R5: A run lasts exactly 256 cycles after the accepting edge. `done_o` is high for exactly one cycle, starting the cycle after the last run cycle, with the final count on `result_o`.
- R6: If either operand is 0, no product bit is ever one and the result is exactly 0.
- R7: The result differs from the exact product a·b/256 by no more than 40 counts.
- R8: Between runs `result_o` holds its last value until a new start is accepted, and it clears to 0 on that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a multiplication; honoured only when idle |
| op_a_i | input | 8 | First operand, value op_a_i/256 |
| op_b_i | input | 8 | Second operand, value op_b_i/256 |
| done_o | output | 1 | One-cycle pulse when the count is final |
| result_o | output | 9 | Count of ones in the product stream, value result_o/256 |

## Verification
On every cycle, the assertions check the following. The done pulse lasts a single cycle and arrives exactly 256 run cycles after the start. The count climbs by at most one per run cycle and holds still while idle. No product one appears while either captured operand is zero. Other behaviour only the bench's scenarios can show: the exact generator sequences and seeds, the capture of the operands and the ignoring of a start during a run, and how close the estimate is to the true product. The bench shows these by comparing the outputs each cycle against a behavioural model and by measuring the error of each result.

// File: rtl/stoch_mul_pkg.sv
package stoch_mul_pkg;

  localparam int unsigned NUM_STREAMS = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/stoch_rst_sync.sv
module stoch_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/stoch_lfsr.sv
module stoch_lfsr #(
  parameter int unsigned        W    = 8,
  parameter logic [W-1:0]       TAPS = 8'hB8,
  parameter logic [W-1:0]       SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         feedback;

  assign feedback = ^(state_q & TAPS);

  always_comb begin
    state_d = state_q;
    if (load_i)      state_d = SEED;
    else if (step_i) state_d = {state_q[W-2:0], feedback};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/stoch_stream_gen.sv
module stoch_stream_gen #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] level_i,
  output logic         bit_o
);

  logic [W-1:0] rnd;

  stoch_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .step_i  (step_i),
    .state_o (rnd)
  );

  assign bit_o = (rnd < level_i);

endmodule

// File: rtl/stoch_ones_counter.sv
module stoch_ones_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (clear_i)            count_d = '0;
    else if (en_i && inc_i) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

endmodule

// File: rtl/stoch_mul.sv
module stoch_mul
  import stoch_mul_pkg::*;
#(
  parameter int unsigned     OP_W   = 8,
  parameter logic [OP_W-1:0] TAPS_A = 8'hB8,
  parameter logic [OP_W-1:0] SEED_A = 8'h01,
  parameter logic [OP_W-1:0] TAPS_B = 8'hE1,
  parameter logic [OP_W-1:0] SEED_B = 8'hA5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  output logic            done_o,
  output logic [OP_W:0]   result_o
);

  localparam int unsigned CNT_W = OP_W + 1;
  localparam logic [NUM_STREAMS-1:0][OP_W-1:0] TAPS_ARR = {TAPS_B, TAPS_A};
  localparam logic [NUM_STREAMS-1:0][OP_W-1:0] SEED_ARR = {SEED_B, SEED_A};

  logic                              rst_core_n;
  run_state_e                        state_q, state_d;
  logic [OP_W-1:0]                   cyc_q, cyc_d;
  logic [NUM_STREAMS-1:0][OP_W-1:0]  op_in, op_q, op_d;
  logic [NUM_STREAMS-1:0]            stream_bits;
  logic                              done_q, done_d;
  logic                              accept, busy, last_cyc, prod_bit;

  stoch_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign op_in    = {op_b_i, op_a_i};
  assign busy     = (state_q == ST_RUN);
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign last_cyc = busy && (cyc_q == '1);

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    cyc_d   = cyc_q;
    done_d  = last_cyc;
    if (accept) begin
      state_d = ST_RUN;
      op_d    = op_in;
      cyc_d   = '0;
    end else if (busy) begin
      cyc_d = cyc_q + 1'b1;
      if (last_cyc) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      cyc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      cyc_q   <= cyc_d;
      done_q  <= done_d;
    end
  end

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
    stoch_stream_gen #(
      .W    (OP_W),
      .TAPS (TAPS_ARR[g]),
      .SEED (SEED_ARR[g])
    ) u_gen (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .load_i  (accept),
      .step_i  (busy),
      .level_i (op_q[g]),
      .bit_o   (stream_bits[g])
    );
  end

  assign prod_bit = &stream_bits;

  stoch_ones_counter #(.CW(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clear_i (accept),
    .en_i    (busy),
    .inc_i   (prod_bit),
    .count_o (result_o)
  );

  assign done_o = done_q;

endmodule

// File: rtl/stoch_mul_chk.sv
module stoch_mul_chk #(
  parameter int unsigned OP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy,
  input logic            prod_bit,
  input logic [OP_W-1:0] op_a_q,
  input logic [OP_W-1:0] op_b_q,
  input logic            done_o,
  input logic [OP_W:0]   result_o
);

  localparam int unsigned WIN = 2 ** OP_W;

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= 0;
    else if (done_o) run_len <= 0;
    else if (busy)   run_len <= run_len + 1;
    else             run_len <= 0;
  end

  // R5: done only after a full window of run cycles
  a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == WIN));

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4: count rises by zero or one per run cycle
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((result_o == $past(result_o)) || (result_o == $past(result_o) + 1'b1)));

  // R4: count bounded by the window
  a_r4_result_range: assert property (@(posedge clk) disable iff (!rst_n)
    result_o <= (OP_W+1)'(WIN));

  // R6: zero operand yields no product ones
  a_r6_zero_no_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((op_a_q == '0) || (op_b_q == '0))) |-> !prod_bit);

  // R8: result held while idle without start
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(result_o));

endmodule

bind stoch_mul stoch_mul_chk #(.OP_W(OP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy     (busy),
  .prod_bit (prod_bit),
  .op_a_q   (op_q[0]),
  .op_b_q   (op_q[1]),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/stoch_mul_bench.sv
module stoch_mul_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] op_a_i = '0;
  logic [7:0] op_b_i = '0;
  logic       done_o;
  logic [8:0] result_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit live   = 0;

  // behavioural reference state
  int m_busy = 0, m_cyc = 0, m_cnt = 0, m_done = 0;
  int m_la = 1, m_lb = 165, m_opa = 0, m_opb = 0;

  always #5 clk = ~clk;

  stoch_mul u_stoch_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i),
    .done_o(done_o), .result_o(result_o)
  );

  function automatic int gen_next(int s, int taps);
    int par = 0;
    for (int k = 0; k < 8; k++) if ((taps >> k) & 1) par ^= (s >> k) & 1;
    return ((s * 2) % 256) + par;
  endfunction

  // R3/R4/R5 reference: generator sequences, AND, count, timing
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cyc = 0; m_cnt = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start_i) begin
          m_busy = 1; m_cyc = 0; m_cnt = 0;
          m_opa = op_a_i; m_opb = op_b_i; m_la = 1; m_lb = 165;
        end
      end else begin
        if (m_la < m_opa && m_lb < m_opb) m_cnt = m_cnt + 1;
        m_la = gen_next(m_la, 'hB8);
        m_lb = gen_next(m_lb, 'hE1);
        if (m_cyc == 255) begin m_busy = 0; m_done = 1; end
        m_cyc = m_cyc + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (live) begin
      check(done_o == m_done[0], "R5 done per cycle", done_o, m_done);
      check(result_o == 9'(m_cnt), "R4 count per cycle", result_o, m_cnt);
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_mul(input int a, input int b, output int res, output int lat);
    @(negedge clk);
    start_i = 1'b1; op_a_i = 8'(a); op_b_i = 8'(b);
    lat = 0;
    do begin
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end while (!done_o && lat < 1000);
    res = result_o;
  endtask

  task automatic check_bound(input int a, input int b, input int res);
    int diff;
    diff = res * 256 - a * b;
    if (diff < 0) diff = -diff;
    check(diff <= 40 * 256, "R7 error bound", res, (a * b) / 256);
  endtask

  initial begin
    int res, lat, hold;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    check(result_o == 9'd0, "R1 reset result", result_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    live = 1;
    check(result_o == 9'd0 && !done_o, "R1 idle after reset", result_o, 0);

    // R3 R4 R5: half times quarter
    run_mul(128, 64, res, lat);
    check(lat == 257, "R5 latency", lat, 257);
    check(res == m_cnt, "R3 R4 model match 128x64", res, m_cnt);
    check_bound(128, 64, res);
    @(negedge clk);
    check(done_o == 1'b0, "R5 single pulse", done_o, 0);

    // R8: hold between runs
    hold = result_o;
    repeat (20) @(negedge clk);
    check(result_o == 9'(hold), "R8 hold while idle", result_o, hold);

    // R6: zero operands
    run_mul(0, 200, res, lat);
    check(res == 0, "R6 zero a", res, 0);
    run_mul(200, 0, res, lat);
    check(res == 0, "R6 zero b", res, 0);

    // R7: assorted operands
    run_mul(255, 255, res, lat); check_bound(255, 255, res);
    run_mul(255, 100, res, lat); check_bound(255, 100, res);
    run_mul(37, 219, res, lat);  check_bound(37, 219, res);
    run_mul(192, 160, res, lat); check_bound(192, 160, res);
    check(res == m_cnt, "R3 model match 192x160", res, m_cnt);

    // R2: start and operand change during a run are ignored
    @(negedge clk);
    start_i = 1'b1; op_a_i = 8'd100; op_b_i = 8'd150;
    @(negedge clk);
    start_i = 1'b0;
    repeat (50) @(negedge clk);
    start_i = 1'b1; op_a_i = 8'd0; op_b_i = 8'd0;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 1000) begin @(negedge clk); lat++; end
    res = result_o;
    check(res == m_cnt, "R2 mid-run start ignored", res, m_cnt);
    check(res > 0, "R2 operands kept from start", res, 1);
    check_bound(100, 150, res);

    // R8: clears on next accepted start
    @(negedge clk);
    start_i = 1'b1; op_a_i = 8'd10; op_b_i = 8'd10;
    @(negedge clk);
    start_i = 1'b0;
    check(result_o <= 9'd1, "R8 clear on start", result_o, 0);
    while (!done_o) @(negedge clk);
    check_bound(10, 10, result_o);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule